// File: doc/BRIEF.md
# Receive Watermark Pause Requester

This block sits beside a receive buffer whose occupancy is reported as a count of stored 4-byte words. It turns that count into a pause-request handshake for the transmit side of an Ethernet MAC. When the stored count climbs to a programmable high mark, the block raises a level request for an XOFF frame. The request stays up until the transmit side acknowledges it.

After the acknowledge, the block counts down a programmable interval measured in pause quanta. A quantum is 512 bit times, and its tick arrives from outside as a single-cycle strobe. If the buffer is still above the low mark when that interval runs out, the block asks for XOFF again. Once the count falls to or below the low mark, the block drops any outstanding request and emits a one-cycle XON strobe.

A software enable and a soft-reset hold keep the requester idle while software reprograms the thresholds. While idle, the request is low, the timer is clear and level changes are ignored. Correct operation assumes the low mark is strictly below the high mark.

Top module: `rx_pause_requester`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pause_req` and `xon_pulse` are 0, whatever the buffer level.
- R2: When the block is enabled and idle, a clock edge at which `fill_words >= hi_mark` makes `pause_req` 1 from that edge on.
- R3: Once raised, `pause_req` stays at 1 until an edge at which `pause_ack` is 1, unless the level drops to the low mark or the block is disabled.
- R4: The edge that accepts `pause_ack` loads a timer with `retx_quanta`. Each later edge with `quanta_tick` at 1 takes one from it. On the first edge after the timer reaches zero, if `fill_words > lo_mark`, `pause_req` goes back to 1.
- R5: With `retx_quanta` = 0, the request comes back on the second edge after the acknowledge, and no tick is needed.
- R6: While a request is pending or the timer is running, an edge with `fill_words <= lo_mark` clears the request and makes `xon_pulse` 1 for exactly one cycle.
- R7: While `enable` is 0 or `soft_rst` is 1, `pause_req` and `xon_pulse` are 0, the timer is cleared and level changes are ignored. When the block is enabled again, it starts from idle.
- R8: At most one request is outstanding. `pause_ack` has no effect while `pause_req` is 0, and `pause_req` and `xon_pulse` are never 1 together.
- R9: A level strictly between the two marks never starts a request from idle.
- R10: `quanta_tick` pulses that arrive before the acknowledge do not shorten the retransmit interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Software enable request |
| soft_rst | input | 1 | Software hold-in-reset |
| fill_words | input | 13 | Stored 4-byte words in the receive buffer |
| hi_mark | input | 13 | High watermark, in words |
| lo_mark | input | 13 | Low watermark, in words |
| retx_quanta | input | 16 | Retransmit interval, in pause quanta |
| quanta_tick | input | 1 | One-cycle strobe per pause quantum |
| pause_ack | input | 1 | Transmit side has taken the XOFF request |
| pause_req | output | 1 | XOFF request level |
| xon_pulse | output | 1 | One-cycle XON request |

## Verification
The hardest state to reach is the timer running out while the level stays between the two marks. At that moment the block must request again, without any new crossing of the high mark. The stimulus gets there by acknowledging a request and then lowering the level to a value above the low mark. It then counts quantum ticks one by one, with idle cycles between them, and checks that the request returns on exactly the edge after the last tick. Further sequences cover a zero interval, ticks that arrive before the acknowledge, and a soft reset in the middle of the countdown.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
   localparam int unsigned WORD_W  = 13;
   localparam int unsigned QUANT_W = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } pr_state_e;
endpackage

// File: rtl/rxp_mark_cmp.sv
module rxp_mark_cmp #(
   parameter int unsigned W = 13
) (
   input  logic [W-1:0] level,
   input  logic [W-1:0] hi_mark,
   input  logic [W-1:0] lo_mark,
   output logic         at_high,
   output logic         at_low
);
   generate
      if (W < 2) begin : g_bad_w
         $error("rxp_mark_cmp: W must be at least 2");
      end
   endgenerate

   always_comb begin
      at_high = (level >= hi_mark);
      at_low  = (level <= lo_mark);
   end
endmodule

// File: rtl/rxp_quanta_timer.sv
module rxp_quanta_timer #(
   parameter int unsigned QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [QW-1:0] load_val,
   input  logic          tick,
   output logic          expired
);
   localparam logic [QW-1:0] ZERO = '0;
   localparam logic [QW-1:0] ONE  = QW'(1);

   generate
      if (QW < 1) begin : g_bad_qw
         $error("rxp_quanta_timer: QW must be at least 1");
      end
   endgenerate

   logic [QW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      remain_q <= ZERO;
      else if (clr)                    remain_q <= ZERO;
      else if (load)                   remain_q <= load_val;
      else if (tick && remain_q != ZERO) remain_q <= remain_q - ONE;
   end

   assign expired = (remain_q == ZERO);

   // R4: with no tick and no load the count holds
   a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !tick) |=> $stable(remain_q));
   // R7: a clear always leaves the timer expired
   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> expired);
endmodule

// File: rtl/rx_pause_requester.sv
module rx_pause_requester
   import rxp_pkg::*;
#(
   parameter int unsigned LVL_W = WORD_W,
   parameter int unsigned QNT_W = QUANT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             soft_rst,
   input  logic [LVL_W-1:0] fill_words,
   input  logic [LVL_W-1:0] hi_mark,
   input  logic [LVL_W-1:0] lo_mark,
   input  logic [QNT_W-1:0] retx_quanta,
   input  logic             quanta_tick,
   input  logic             pause_ack,
   output logic             pause_req,
   output logic             xon_pulse
);
   generate
      if (QNT_W > 32) begin : g_bad_qnt
         $error("rx_pause_requester: QNT_W above 32 is not supported");
      end
   endgenerate

   logic      active;
   logic      at_high, at_low, expired;
   logic      tmr_load;
   logic      xon_d;
   pr_state_e state_q, state_d;

   assign active = enable && !soft_rst;

   rxp_mark_cmp #(.W(LVL_W)) u_cmp (
      .level   (fill_words),
      .hi_mark (hi_mark),
      .lo_mark (lo_mark),
      .at_high (at_high),
      .at_low  (at_low)
   );

   rxp_quanta_timer #(.QW(QNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!active),
      .load     (tmr_load),
      .load_val (retx_quanta),
      .tick     (quanta_tick),
      .expired  (expired)
   );

   always_comb begin
      state_d  = state_q;
      xon_d    = 1'b0;
      tmr_load = 1'b0;
      if (!active) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (at_high) state_d = ST_REQ;
            ST_REQ: begin
               if (at_low) begin
                  state_d = ST_IDLE;
                  xon_d   = 1'b1;
               end else if (pause_ack) begin
                  state_d  = ST_WAIT;
                  tmr_load = 1'b1;
               end
            end
            ST_WAIT: begin
               if (at_low) begin
                  state_d = ST_IDLE;
                  xon_d   = 1'b1;
               end else if (expired) begin
                  state_d = ST_REQ;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         xon_pulse <= 1'b0;
      end else begin
         state_q   <= state_d;
         xon_pulse <= xon_d;
      end
   end

   assign pause_req = (state_q == ST_REQ);

   // R2: a high level seen while idle raises the request
   a_r2_raise_at_high: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !pause_req && !expired && at_high && !at_low && !xon_pulse && state_q == ST_IDLE) |=> pause_req);
   // R3: the request holds until acknowledged
   a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_req && active && !pause_ack && !at_low) |=> pause_req);
   // R4: no request while the timer is still counting
   a_r4_quiet_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && active && !expired && !at_low) |=> !pause_req);
   // R6: XON lasts one cycle
   a_r6_xon_single: assert property (@(posedge clk) disable iff (!rst_n)
      xon_pulse |=> !xon_pulse);
   // R7: nothing is driven while disabled or held
   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!pause_req && !xon_pulse));
   // R8: XOFF and XON are never requested together
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pause_req && xon_pulse));
endmodule

// File: tb/rx_pause_requester_tb.sv
module rx_pause_requester_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        soft_rst = 1'b0;
   logic [12:0] fill_words = '0;
   logic [12:0] hi_mark = 13'd100;
   logic [12:0] lo_mark = 13'd20;
   logic [15:0] retx_quanta = 16'd2;
   logic        quanta_tick = 1'b0;
   logic        pause_ack = 1'b0;
   logic        pause_req, xon_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit reported = 0;

   always #10 clk = ~clk;

   rx_pause_requester dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
      .fill_words(fill_words), .hi_mark(hi_mark), .lo_mark(lo_mark),
      .retx_quanta(retx_quanta), .quanta_tick(quanta_tick),
      .pause_ack(pause_ack), .pause_req(pause_req), .xon_pulse(xon_pulse)
   );

   typedef struct packed {
      logic        en;
      logic        srst;
      logic [12:0] lvl;
      logic        ack;
      logic        tick;
      logic        req;
      logic        xon;
      logic [3:0]  rid;
   } vec_t;

   // hi=100 lo=20 retx=2; rid names the requirement checked
   localparam vec_t TBL [14] = '{
      '{1'b1, 1'b0, 13'd50,  1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 between marks
      '{1'b1, 1'b0, 13'd100, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 reach high
      '{1'b1, 1'b0, 13'd100, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 tick, no ack
      '{1'b1, 1'b0, 13'd100, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 hold
      '{1'b1, 1'b0, 13'd100, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 ack, load 2
      '{1'b1, 1'b0, 13'd80,  1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 tick -> 1
      '{1'b1, 1'b0, 13'd80,  1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
      '{1'b1, 1'b0, 13'd80,  1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 tick -> 0
      '{1'b1, 1'b0, 13'd80,  1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 re-request
      '{1'b1, 1'b0, 13'd80,  1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
      '{1'b1, 1'b0, 13'd20,  1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 low mark
      '{1'b1, 1'b0, 13'd20,  1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 single
      '{1'b1, 1'b0, 13'd60,  1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 stray ack
      '{1'b1, 1'b0, 13'd99,  1'b0, 1'b0, 1'b0, 1'b0, 4'd9}   // R9 just below
   };

   task automatic check(input logic exp_req, input logic exp_xon, input string rq);
      n_checks++;
      if (pause_req !== exp_req || xon_pulse !== exp_xon) begin
         n_fail++;
         $display("FAIL %s: req=%b xon=%b expected req=%b xon=%b at %0t",
                  rq, pause_req, xon_pulse, exp_req, exp_xon, $time);
      end
   endtask

   task automatic step(input logic en, input logic srst, input logic [12:0] lvl,
                       input logic ack, input logic tick,
                       input logic exp_req, input logic exp_xon, input string rq);
      enable = en; soft_rst = srst; fill_words = lvl;
      pause_ack = ack; quanta_tick = tick;
      @(posedge clk);
      #5;
      check(exp_req, exp_xon, rq);
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      end
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
   end

   initial begin
      // R1: reset state with a high level present
      enable = 1'b1; fill_words = 13'd300;
      @(posedge clk); @(posedge clk); #5;
      check(1'b0, 1'b0, "R1");
      rst_n = 1'b1;
      fill_words = 13'd0;
      @(posedge clk); #5;
      check(1'b0, 1'b0, "R1");

      foreach (TBL[i]) begin
         step(TBL[i].en, TBL[i].srst, TBL[i].lvl, TBL[i].ack, TBL[i].tick,
              TBL[i].req, TBL[i].xon, $sformatf("R%0d row%0d", TBL[i].rid, i));
      end

      // R7: disabled ignores level, re-enable starts from idle
      step(1'b0, 1'b0, 13'd200, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      step(1'b0, 1'b0, 13'd200, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
      step(1'b1, 1'b0, 13'd200, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
      step(1'b1, 1'b1, 13'd200, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      step(1'b1, 1'b1, 13'd10,  1'b0, 1'b0, 1'b0, 1'b0, "R7");
      step(1'b1, 1'b0, 13'd50,  1'b0, 1'b0, 1'b0, 1'b0, "R7");

      // R7: soft reset mid-countdown clears the timer
      retx_quanta = 16'd3;
      step(1'b1, 1'b0, 13'd100, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, 13'd100, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, 13'd60,  1'b0, 1'b1, 1'b0, 1'b0, "R4");
      step(1'b1, 1'b1, 13'd60,  1'b0, 1'b0, 1'b0, 1'b0, "R7");
      for (int k = 0; k < 4; k++)
         step(1'b1, 1'b0, 13'd60, 1'b0, 1'b1, 1'b0, 1'b0, "R7");

      // R5: zero interval re-requests two edges after ack
      retx_quanta = 16'd0;
      step(1'b1, 1'b0, 13'd100, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, 13'd100, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      step(1'b1, 1'b0, 13'd100, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
      step(1'b1, 1'b0, 13'd100, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      step(1'b1, 1'b0, 13'd10,  1'b0, 1'b0, 1'b0, 1'b1, "R6");
      step(1'b1, 1'b0, 13'd10,  1'b0, 1'b0, 1'b0, 1'b0, "R6");

      // R10: ticks before ack do not count
      retx_quanta = 16'd2;
      step(1'b1, 1'b0, 13'd100, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
      for (int k = 0; k < 3; k++)
         step(1'b1, 1'b0, 13'd100, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
      step(1'b1, 1'b0, 13'd100, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
      step(1'b1, 1'b0, 13'd50,  1'b0, 1'b1, 1'b0, 1'b0, "R10");
      step(1'b1, 1'b0, 13'd50,  1'b0, 1'b1, 1'b0, 1'b0, "R10");
      step(1'b1, 1'b0, 13'd50,  1'b0, 1'b0, 1'b1, 1'b0, "R4");

      report();
   end
endmodule